// File: doc/BRIEF.md
# Segment Address Translator

This block maps a 14-bit virtual address to a 16-bit physical address through a four-entry segment table held in flops. The two most significant address bits pick an entry. The remaining twelve bits form an offset, and that offset is added to the entry's base. Each entry also holds a length limit, a valid flag and a write-enable flag. The valid flag marks whether the segment is in use. The write-enable flag decides whether the segment takes stores or only loads and instruction fetches.

A request carries an address and an access kind. The table lookup, the add and the three checks are combinational. The result is captured in an output register, so every request gets its response one cycle later. A rejected access returns a two-bit cause code instead of an address. The table is loaded only through a separate privileged write port, and the translation path can never modify it.

Top module: `seg_xlate`

## Requirements
- R1: After reset `rsp_valid` is 0 and every table entry is marked unused, so any request made before a table write returns fault code 01.
- R2: A request accepted with `req_valid`=1 produces `rsp_valid`=1 on the next cycle. A cycle with `req_valid`=0 produces `rsp_valid`=0, `rsp_fault`=00 and `rsp_paddr`=0 on the next cycle.
- R3: Address bits 13:12 select the table entry and bits 11:0 form the offset. A permitted access returns `rsp_paddr` = base + offset as an unsigned 16-bit sum, where base is 15 bits, so the sum never wraps.
- R4: An access to an entry whose valid flag is 0 returns fault code 01.
- R5: On a valid entry, an offset greater than or equal to the entry's 13-bit limit returns fault code 10. A limit of 0 rejects every offset. A limit of 4096 accepts every offset.
- R6: Access kind is coded 00 load, 01 store, 10 fetch, 11 load. A store to a valid entry whose write-enable flag is 0, with its offset inside the limit, returns fault code 11. Loads and fetches are never refused for protection.
- R7: When several checks fail, the reported cause follows the priority 01 over 10 over 11.
- R8: Any response with a non-zero fault code carries `rsp_paddr` = 0.
- R9: A table entry changes only on a cycle with `cfg_we`=1, and only the entry named by `cfg_idx`. A request presented in the same cycle as a write to its entry is translated with the old contents. Requests in later cycles see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Privileged table write strobe |
| cfg_idx | input | 2 | Entry to write |
| cfg_base | input | 15 | Physical base for the entry |
| cfg_limit | input | 13 | Segment length in bytes (0 to 4096) |
| cfg_used | input | 1 | Valid flag for the entry |
| cfg_wr_ok | input | 1 | 1 lets the segment take stores |
| req_valid | input | 1 | A translation request is present |
| req_vaddr | input | 14 | Virtual address |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 load |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 16 | Translated physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 unused segment, 10 beyond limit, 11 store refused |

## Verification
The hardest case to reach is a request that arrives in the same cycle as a privileged write to the entry it selects, because the response must reflect the contents from before that write. The random phase writes the table on about a third of cycles and draws the request segment from the same small index range, so such collisions happen often. A directed step also forces one. The bench's table model is updated only after each expected result has been computed. Limits are drawn with extra weight at 0, 4096 and the offset itself, so that the boundary and priority cases come up often.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int VA_W  = 14,
  parameter int SEL_W = 2,
  parameter int PA_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [SEL_W-1:0]       cfg_idx,
  input  logic [PA_W-2:0]        cfg_base,
  input  logic [VA_W-SEL_W:0]    cfg_limit,
  input  logic                   cfg_used,
  input  logic                   cfg_wr_ok,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic [1:0]             req_kind,
  output logic                   rsp_valid,
  output logic [PA_W-1:0]        rsp_paddr,
  output logic [1:0]             rsp_fault
);
  localparam int OFF_W  = VA_W - SEL_W;
  localparam int LIM_W  = OFF_W + 1;
  localparam int BASE_W = PA_W - 1;
  localparam int NSEG   = 1 << SEL_W;

  localparam logic [1:0] F_NONE = 2'b00;
  localparam logic [1:0] F_GONE = 2'b01;
  localparam logic [1:0] F_LIM  = 2'b10;
  localparam logic [1:0] F_PROT = 2'b11;
  localparam logic [1:0] K_STORE = 2'b01;

  logic [BASE_W-1:0] t_base [NSEG];
  logic [LIM_W-1:0]  t_lim  [NSEG];
  logic [NSEG-1:0]   t_used;
  logic [NSEG-1:0]   t_wok;

  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          t_used[g] <= 1'b0;
          t_wok[g]  <= 1'b0;
          t_base[g] <= '0;
          t_lim[g]  <= '0;
        end else if (cfg_we && cfg_idx == SEL_W'(g)) begin
          t_used[g] <= cfg_used;
          t_wok[g]  <= cfg_wr_ok;
          t_base[g] <= cfg_base;
          t_lim[g]  <= cfg_limit;
        end
      end

      assert_table_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_idx == SEL_W'(g)) |=> ($stable(t_base[g]) && $stable(t_lim[g])
                                               && $stable(t_used[g]) && $stable(t_wok[g])));
    end
  endgenerate

  wire [SEL_W-1:0] seg = req_vaddr[VA_W-1:OFF_W];
  wire [OFF_W-1:0] off = req_vaddr[OFF_W-1:0];

  wire over    = {1'b0, off} >= t_lim[seg];
  wire refused = (req_kind == K_STORE) && !t_wok[seg];

  logic [1:0] cause;
  always_comb begin
    if (!t_used[seg])  cause = F_GONE;
    else if (over)     cause = F_LIM;
    else if (refused)  cause = F_PROT;
    else               cause = F_NONE;
  end

  wire [PA_W-1:0] sum = PA_W'(t_base[seg]) + PA_W'(off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= F_NONE;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid ? cause : F_NONE;
      rsp_paddr <= (req_valid && cause == F_NONE) ? sum : '0;
    end
  end

  assert_unused_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !t_used[seg]) |=> (rsp_valid && rsp_fault == F_GONE));

  assert_limit_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && t_used[seg] && over) |=> (rsp_fault == F_LIM));

  assert_store_prot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && t_used[seg] && !over && req_kind == K_STORE && !t_wok[seg])
      |=> (rsp_fault == F_PROT));

  assert_fault_zero_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != F_NONE) |-> (rsp_valid && rsp_paddr == '0));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_fault == F_NONE && rsp_paddr == '0));
endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_idx = 0;
  logic [14:0] cfg_base = 0;
  logic [12:0] cfg_limit = 0;
  logic        cfg_used = 0;
  logic        cfg_wr_ok = 0;
  logic        req_valid = 0;
  logic [13:0] req_vaddr = 0;
  logic [1:0]  req_kind = 0;
  logic        rsp_valid;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int total = 0;
  int bad = 0;

  logic [14:0] m_base [4];
  logic [12:0] m_lim  [4];
  logic        m_used [4];
  logic        m_wok  [4];

  always #5 clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_used(cfg_used),
    .cfg_wr_ok(cfg_wr_ok), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault)
  );

  function automatic logic [1:0] exp_fault(logic [13:0] va, logic [1:0] k);
    logic [1:0] s = va[13:12];
    if (!m_used[s]) return 2'b01;
    if ({1'b0, va[11:0]} >= m_lim[s]) return 2'b10;
    if (k == 2'b01 && !m_wok[s]) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [15:0] exp_addr(logic [13:0] va, logic [1:0] k);
    if (exp_fault(va, k) != 2'b00) return 16'd0;
    return {1'b0, m_base[va[13:12]]} + {4'd0, va[11:0]};
  endfunction

  task automatic check(string tag, logic v, logic [15:0] pa, logic [1:0] f);
    total++;
    if (rsp_valid !== v || rsp_paddr !== pa || rsp_fault !== f) begin
      bad++;
      $display("FAIL %s: got v=%0b pa=%h f=%b expected v=%0b pa=%h f=%b",
               tag, rsp_valid, rsp_paddr, rsp_fault, v, pa, f);
    end
  endtask

  task automatic step(string tag, logic we, logic [1:0] idx, logic [14:0] b,
                      logic [12:0] l, logic u, logic w,
                      logic rv, logic [13:0] va, logic [1:0] k);
    logic [1:0] ef;
    logic [15:0] ea;
    @(negedge clk);
    cfg_we = we; cfg_idx = idx; cfg_base = b; cfg_limit = l;
    cfg_used = u; cfg_wr_ok = w;
    req_valid = rv; req_vaddr = va; req_kind = k;
    ef = rv ? exp_fault(va, k) : 2'b00;
    ea = rv ? exp_addr(va, k) : 16'd0;
    if (we) begin
      m_base[idx] = b; m_lim[idx] = l; m_used[idx] = u; m_wok[idx] = w;
    end
    @(posedge clk);
    #1;
    check(tag, rv, ea, ef);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    for (int i = 0; i < 4; i++) begin
      m_base[i] = 0; m_lim[i] = 0; m_used[i] = 0; m_wok[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 0, 16'd0, 2'b00);
    @(negedge clk); rst_n = 1;

    step("R1 empty table", 0, 0, 0, 0, 0, 0, 1, 14'h0240, 2'b00);
    step("R1 empty table seg3", 0, 0, 0, 0, 0, 0, 1, 14'h3002, 2'b10);
    // load: code ro, data rw, seg2 unused, stack rw
    step("R9 write hidden", 1, 0, 15'h4000, 13'h0700, 1, 0, 1, 14'h0240, 2'b00);
    step("R9 write visible R3", 1, 1, 15'h0000, 13'h0500, 1, 1, 1, 14'h0240, 2'b10);
    step("R3 data", 1, 3, 15'h2000, 13'h1000, 1, 1, 1, 14'h1108, 2'b01);
    step("R4 unused seg", 0, 0, 0, 0, 0, 0, 1, 14'h265c, 2'b00);
    step("R3 stack top", 0, 0, 0, 0, 0, 0, 1, 14'h3fff, 2'b01);
    step("R5 over limit", 0, 0, 0, 0, 0, 0, 1, 14'h1600, 2'b00);
    step("R5 at limit", 0, 0, 0, 0, 0, 0, 1, 14'h1500, 2'b00);
    step("R5 below limit", 0, 0, 0, 0, 0, 0, 1, 14'h14ff, 2'b01);
    step("R6 store ro", 0, 0, 0, 0, 0, 0, 1, 14'h0100, 2'b01);
    step("R6 fetch ro", 0, 0, 0, 0, 0, 0, 1, 14'h0100, 2'b10);
    step("R6 kind11 load", 0, 0, 0, 0, 0, 0, 1, 14'h0100, 2'b11);
    step("R7 limit over prot", 0, 0, 0, 0, 0, 0, 1, 14'h0800, 2'b01);
    step("R2 idle", 0, 0, 0, 0, 0, 0, 0, 14'h0100, 2'b00);
    step("R5 zero limit", 1, 2, 15'h7fff, 13'h0000, 1, 1, 1, 14'h2000, 2'b00);
    step("R5 zero limit seen", 0, 0, 0, 0, 0, 0, 1, 14'h2000, 2'b00);
    step("R3 max sum", 1, 2, 15'h7fff, 13'h1000, 1, 1, 1, 14'h2fff, 2'b01);
    step("R3 max sum seen", 0, 0, 0, 0, 0, 0, 1, 14'h2fff, 2'b01);
    step("R7 unused over prot", 1, 0, 15'h0, 13'h0, 0, 0, 1, 14'h0fff, 2'b01);
    step("R7 unused over prot seen", 0, 0, 0, 0, 0, 0, 1, 14'h0fff, 2'b01);

    for (int n = 0; n < 3000; n++) begin
      logic we, u, w, rv;
      logic [1:0] idx, k;
      logic [14:0] b;
      logic [12:0] l;
      logic [13:0] va;
      int pick;
      we = ($urandom % 3) == 0;
      idx = 2'($urandom);
      b = 15'($urandom);
      u = ($urandom % 5) != 0;
      w = 1'($urandom);
      rv = ($urandom % 6) != 0;
      k = 2'($urandom);
      va = 14'($urandom);
      if (($urandom % 2) == 0) va[13:12] = idx;
      pick = $urandom % 5;
      if (pick == 0) l = 13'h0000;
      else if (pick == 1) l = 13'h1000;
      else if (pick == 2) l = {1'b0, va[11:0]} + 13'($urandom % 2);
      else l = 13'($urandom % 13'h1001);
      step("R9 random", we, idx, b, l, u, w, rv, va, k);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule